// File: doc/BRIEF.md
# Masked Line Response Packer

This block sits on the host end of an accelerator link and trims the data sent back for line reads. Each request names a 128-byte line and an 8-bit selection mask, one bit per 16-byte sub-block. The block keeps a small table of lines that are waiting on memory. A request for a line that is already in the table does not start a new memory read. Its mask is ORed into the stored one. When memory hands back the whole line, the block sends a header beat followed by only the sub-blocks the merged mask selects.

A line's table entry is released when its header beat leaves. The mask that travels with the response is therefore final at that point. A request arriving afterwards for the same line opens a fresh entry and starts a new memory read. A request with an empty mask is taken and flagged as an error. It touches neither the table nor memory. Memory completions are matched to entries by a tag that the block issues with each read.

Top module: `mask_xfer_unit`

## Requirements
- R1: A request with a non-zero mask for a line not held in the table takes a free entry. It produces exactly one memory read carrying that line and the entry's tag.
- R2: A request whose line matches a table entry whose header has not yet been sent ORs its mask into that entry. It causes no further memory read.
- R3: A response starts with one beat where `rsp_hdr`=1. That beat carries the final mask in `rsp_data[7:0]` and the line in `rsp_data[8 +: LINE_W]`, with zeros above.
- R4: The header beat is followed by one beat (`rsp_hdr`=0) per set mask bit, in ascending sub-block order. The beat for sub-block k is `mrsp_data[128k +: 128]`. No further beats follow.
- R5: A request with mask 0 is accepted regardless of table occupancy and raises `req_reject` for one cycle, on the cycle after acceptance. It causes no memory read and no response.
- R6: The table holds ENTRIES (4) lines. When all are occupied, a request for an unlisted line sees `req_ready`=0 until an entry is released.
- R7: An entry is released when its header beat is accepted. A later request for the same line allocates a new entry and issues a new memory read.
- R8: After reset, `req_ready`=1 and `mem_valid`, `rsp_valid` and `req_reject` are 0.
- R9: Once raised, `mem_valid` and `rsp_valid` stay high until accepted. A data beat stays unchanged while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_line | input | LINE_W | Line address of request |
| req_mask | input | NSUB | Wanted sub-blocks |
| req_reject | output | 1 | Empty-mask request was dropped |
| mem_valid | output | 1 | Memory read pending |
| mem_ready | input | 1 | Memory takes the read |
| mem_line | output | LINE_W | Line to read |
| mem_tag | output | TAG_W | Entry tag of the read |
| mrsp_valid | input | 1 | Memory line returned |
| mrsp_ready | output | 1 | Block can take a returned line |
| mrsp_tag | input | TAG_W | Tag of returned line |
| mrsp_data | input | NSUB*SUB_W | Full returned line |
| rsp_valid | output | 1 | Link beat present |
| rsp_ready | input | 1 | Link takes the beat |
| rsp_hdr | output | 1 | Beat is a header |
| rsp_data | output | SUB_W | Beat payload |

## Verification
Several properties are checked on every cycle. At most one live entry matches an incoming line. A header never carries an empty mask. A stalled beat or read stays valid, and a data beat does not change while stalled. The data phase never runs with nothing left to send. A reject pulse is always traced to an empty-mask request. Only the bench scenarios can show end-to-end effects. These are merged masks that appear as fewer memory reads, the exact beat order and payload, the stall on a full table, and a fresh read after the header has been sent.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {ENT_FREE, ENT_ISSUE, ENT_WAIT} ent_st_e;
  typedef enum logic [1:0] {PK_IDLE, PK_HDR, PK_DATA} pk_st_e;
endpackage

// File: rtl/mt_entry_table.sv
module mt_entry_table
  import mt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int NSUB    = 8,
  parameter int TAG_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [NSUB-1:0]   req_mask,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [LINE_W-1:0] mem_line,
  output logic [TAG_W-1:0]  mem_tag,
  input  logic              free_valid,
  input  logic [TAG_W-1:0]  free_tag,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  output logic [NSUB-1:0]   rd_mask
);
  ent_st_e           st_q   [ENTRIES];
  ent_st_e           st_d   [ENTRIES];
  logic [LINE_W-1:0] line_q [ENTRIES];
  logic [NSUB-1:0]   mask_q [ENTRIES];
  logic [NSUB-1:0]   mask_d [ENTRIES];
  logic [ENTRIES-1:0] hit_vec, free_vec, iss_vec, ld_en, mk_en;
  logic [TAG_W-1:0]  hit_idx, alloc_idx, iss_idx;
  logic              hit, any_free, zero_mask, acc;

  always_comb begin
    hit_vec  = '0;
    free_vec = '0;
    iss_vec  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i]  = (st_q[i] != ENT_FREE) && (line_q[i] == req_line) &&
                    !(free_valid && (free_tag == TAG_W'(i)));
      free_vec[i] = (st_q[i] == ENT_FREE);
      iss_vec[i]  = (st_q[i] == ENT_ISSUE);
    end
    hit_idx   = '0;
    alloc_idx = '0;
    iss_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx   = TAG_W'(i);
      if (free_vec[i]) alloc_idx = TAG_W'(i);
      if (iss_vec[i])  iss_idx   = TAG_W'(i);
    end
  end

  assign hit       = |hit_vec;
  assign any_free  = |free_vec;
  assign zero_mask = (req_mask == '0);
  assign req_ready = zero_mask || hit || any_free;
  assign acc       = req_valid && req_ready && !zero_mask;

  assign mem_valid = |iss_vec;
  assign mem_tag   = iss_idx;
  assign mem_line  = line_q[iss_idx];
  assign rd_line   = line_q[rd_tag];
  assign rd_mask   = mask_q[rd_tag];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_d[i]   = st_q[i];
      mask_d[i] = mask_q[i];
      ld_en[i]  = 1'b0;
      mk_en[i]  = 1'b0;
      if (free_valid && (free_tag == TAG_W'(i))) st_d[i] = ENT_FREE;
      if (mem_valid && mem_ready && (iss_idx == TAG_W'(i))) st_d[i] = ENT_WAIT;
      if (acc && hit && (hit_idx == TAG_W'(i))) begin
        mask_d[i] = mask_q[i] | req_mask;
        mk_en[i]  = 1'b1;
      end
      if (acc && !hit && (alloc_idx == TAG_W'(i))) begin
        st_d[i]   = ENT_ISSUE;
        mask_d[i] = req_mask;
        mk_en[i]  = 1'b1;
        ld_en[i]  = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]   <= ENT_FREE;
        line_q[g] <= '0;
        mask_q[g] <= '0;
      end else begin
        st_q[g] <= st_d[g];
        if (ld_en[g]) line_q[g] <= req_line;
        if (mk_en[g]) mask_q[g] <= mask_d[g];
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(hit_vec) <= 1); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid); // R9
endmodule

// File: rtl/mt_packer.sv
module mt_packer
  import mt_pkg::*;
#(
  parameter int NSUB   = 8,
  parameter int SUB_W  = 128,
  parameter int LINE_W = 26,
  parameter int TAG_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mrsp_valid,
  output logic                  mrsp_ready,
  input  logic [TAG_W-1:0]      mrsp_tag,
  input  logic [NSUB*SUB_W-1:0] mrsp_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hdr,
  output logic [SUB_W-1:0]      rsp_data,
  input  logic [LINE_W-1:0]     rd_line,
  input  logic [NSUB-1:0]       rd_mask,
  output logic [TAG_W-1:0]      cur_tag,
  output logic                  hdr_fire
);
  localparam int SEL_W = $clog2(NSUB);

  pk_st_e                st_q, st_d;
  logic [TAG_W-1:0]      tag_q;
  logic [NSUB*SUB_W-1:0] buf_q;
  logic [NSUB-1:0]       rem_q, rem_d;
  logic [SEL_W-1:0]      sel;
  logic                  cap_en;

  always_comb begin
    sel = '0;
    for (int i = NSUB - 1; i >= 0; i--) if (rem_q[i]) sel = SEL_W'(i);
  end

  assign mrsp_ready = (st_q == PK_IDLE);
  assign cap_en     = mrsp_ready && mrsp_valid;
  assign rsp_valid  = (st_q != PK_IDLE);
  assign rsp_hdr    = (st_q == PK_HDR);
  assign hdr_fire   = rsp_hdr && rsp_ready;
  assign cur_tag    = tag_q;
  assign rsp_data   = rsp_hdr ? SUB_W'({rd_line, rd_mask}) : buf_q[sel*SUB_W +: SUB_W];

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    case (st_q)
      PK_IDLE: if (mrsp_valid) st_d = PK_HDR;
      PK_HDR: if (rsp_ready) begin
        rem_d = rd_mask;
        st_d  = PK_DATA;
      end
      PK_DATA: if (rsp_ready) begin
        rem_d      = rem_q;
        rem_d[sel] = 1'b0;
        if (rem_d == '0) st_d = PK_IDLE;
      end
      default: st_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PK_IDLE;
      rem_q <= '0;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      if (cap_en) tag_q <= mrsp_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) buf_q <= mrsp_data;
  end

  AST_DATA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PK_DATA |-> rem_q != '0); // R4
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid); // R9
  AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hdr && !rsp_ready |=> $stable(rsp_data)); // R9
  AST_HDR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hdr |-> rd_mask != '0); // R3
endmodule

// File: rtl/mask_xfer_unit.sv
module mask_xfer_unit #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int NSUB    = 8,
  parameter int SUB_W   = 128,
  parameter int TAG_W   = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LINE_W-1:0]     req_line,
  input  logic [NSUB-1:0]       req_mask,
  output logic                  req_reject,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [LINE_W-1:0]     mem_line,
  output logic [TAG_W-1:0]      mem_tag,
  input  logic                  mrsp_valid,
  output logic                  mrsp_ready,
  input  logic [TAG_W-1:0]      mrsp_tag,
  input  logic [NSUB*SUB_W-1:0] mrsp_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hdr,
  output logic [SUB_W-1:0]      rsp_data
);
  logic [1:0]        sync_q;
  logic              rst_n_s;
  logic              rej_q, rej_d;
  logic              hdr_fire;
  logic [TAG_W-1:0]  cur_tag;
  logic [LINE_W-1:0] rd_line;
  logic [NSUB-1:0]   rd_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_s = sync_q[1];

  assign rej_d = req_valid && req_ready && (req_mask == '0);
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rej_q <= 1'b0;
    else          rej_q <= rej_d;
  end
  assign req_reject = rej_q;

  mt_entry_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .NSUB(NSUB), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_n_s),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line), .req_mask(req_mask),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line), .mem_tag(mem_tag),
    .free_valid(hdr_fire), .free_tag(cur_tag),
    .rd_tag(cur_tag), .rd_line(rd_line), .rd_mask(rd_mask)
  );

  mt_packer #(.NSUB(NSUB), .SUB_W(SUB_W), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_pk (
    .clk(clk), .rst_n(rst_n_s),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr), .rsp_data(rsp_data),
    .rd_line(rd_line), .rd_mask(rd_mask), .cur_tag(cur_tag), .hdr_fire(hdr_fire)
  );

  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_reject |-> $past(req_valid && (req_mask == '0))); // R5
endmodule

// File: tb/sim_mask_xfer_unit.sv
`timescale 1ns/1ps
module sim_mask_xfer_unit;
  localparam int LW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [7:0] req_mask = '0;
  logic mem_ready = 1'b1;
  logic mrsp_valid = 1'b0;
  logic [1:0] mrsp_tag = '0;
  logic [1023:0] mrsp_data = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, req_reject, mem_valid, mrsp_ready, rsp_valid, rsp_hdr;
  logic [LW-1:0] mem_line;
  logic [1:0] mem_tag;
  logic [127:0] rsp_data;

  always #10 clk = ~clk;

  mask_xfer_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_mask(req_mask), .req_reject(req_reject),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line), .mem_tag(mem_tag),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr), .rsp_data(rsp_data)
  );

  int n_chk = 0, n_fail = 0, mem_cnt = 0, rej_cnt = 0, rsp_cnt = 0;
  bit live = 0, throttle = 0, prev_stall = 0, prev_mstall = 0;
  logic [128:0] exp_q[$];
  logic [LW-1:0] mq_line[$];
  logic [1:0] mq_tag[$];

  function automatic logic [127:0] dsub(input logic [LW-1:0] ln, input int k);
    return {6'd0, ln, 32'(k), 32'hC0DE_0000 + 32'(k), ~{6'd0, ln}};
  endfunction

  task automatic check(input string rq, input logic [128:0] act, input logic [128:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ready throttling
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      rsp_ready = !throttle || (cyc % 3 != 0);
      mem_ready = !throttle || (cyc % 4 != 1);
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (live) begin
      if (prev_stall) check("R9 rsp_valid held", 129'(rsp_valid), 129'(1));
      if (prev_mstall) check("R9 mem_valid held", 129'(mem_valid), 129'(1));
      prev_stall  = rsp_valid && !rsp_ready;
      prev_mstall = mem_valid && !mem_ready;
      if (mem_valid && mem_ready) begin
        mem_cnt++;
        mq_line.push_back(mem_line);
        mq_tag.push_back(mem_tag);
      end
      if (req_reject) rej_cnt++;
      if (rsp_valid && rsp_ready) begin
        rsp_cnt++;
        if (exp_q.size() == 0) check("R4 unexpected beat", {rsp_hdr, rsp_data}, 129'h0);
        else check("R3/R4 beat", {rsp_hdr, rsp_data}, exp_q.pop_front());
      end
    end
  end

  task automatic send_req(input logic [LW-1:0] ln, input logic [7:0] m);
    @(posedge clk); #2;
    req_valid = 1'b1; req_line = ln; req_mask = m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 1'b0; req_mask = '0;
  endtask

  task automatic mem_return(input logic [LW-1:0] ln, input logic [7:0] m);
    int idx = -1;
    logic [127:0] hw;
    for (int i = 0; i < mq_line.size(); i++) if (idx < 0 && mq_line[i] == ln) idx = i;
    check("R1 memory read seen for line", 129'(idx >= 0), 129'(1));
    if (idx < 0) return;
    hw = '0; hw[7:0] = m; hw[8 +: LW] = ln;
    exp_q.push_back({1'b1, hw});
    for (int k = 0; k < 8; k++) if (m[k]) exp_q.push_back({1'b0, dsub(ln, k)});
    @(posedge clk); #2;
    mrsp_valid = 1'b1; mrsp_tag = mq_tag[idx];
    for (int k = 0; k < 8; k++) mrsp_data[k*128 +: 128] = dsub(ln, k);
    mq_line.delete(idx); mq_tag.delete(idx);
    @(negedge clk);
    while (!mrsp_ready) @(negedge clk);
    @(posedge clk); #2;
    mrsp_valid = 1'b0;
  endtask

  task automatic drain(input string rq);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    check(rq, 129'(exp_q.size()), 129'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, r0, s0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 req_ready", 129'(req_ready), 129'(1));
    check("R8 mem_valid", 129'(mem_valid), 129'(0));
    check("R8 rsp_valid", 129'(rsp_valid), 129'(0));
    check("R8 req_reject", 129'(req_reject), 129'(0));
    live = 1;

    // R1 / R2: merge while pending
    send_req(26'h0A0, 8'h01);
    repeat (3) @(negedge clk);
    send_req(26'h0A0, 8'h80);
    send_req(26'h0A0, 8'h10);
    repeat (3) @(negedge clk);
    check("R2 one read for merged line", 129'(mem_cnt), 129'(1));
    check("R1 read line", 129'(mq_line[0]), 129'(26'h0A0));
    mem_return(26'h0A0, 8'h91);
    drain("R4 merged response drained");
    check("R4 beat count", 129'(rsp_cnt), 129'(4));

    // R5: empty mask
    c0 = mem_cnt; r0 = rej_cnt; s0 = rsp_cnt;
    send_req(26'h0B0, 8'h00);
    repeat (4) @(negedge clk);
    check("R5 reject pulse", 129'(rej_cnt), 129'(r0 + 1));
    check("R5 no memory read", 129'(mem_cnt), 129'(c0));
    check("R5 no response", 129'(rsp_cnt), 129'(s0));

    // R6: full table, with throttled handshakes (R9)
    throttle = 1;
    c0 = mem_cnt;
    send_req(26'h101, 8'hFF);
    send_req(26'h102, 8'h02);
    send_req(26'h103, 8'h40);
    send_req(26'h104, 8'h81);
    repeat (8) @(negedge clk);
    check("R1 four reads", 129'(mem_cnt), 129'(c0 + 4));
    fork
      send_req(26'h105, 8'h0C);
      begin
        @(posedge clk);
        repeat (3) begin
          @(negedge clk);
          check("R6 ready low when full", 129'(req_ready), 129'(0));
        end
        mem_return(26'h101, 8'hFF);
      end
    join
    repeat (8) @(negedge clk);
    check("R6 fifth line read after release", 129'(mem_cnt), 129'(c0 + 5));
    send_req(26'h103, 8'h01);
    repeat (3) @(negedge clk);
    check("R2 merge while full", 129'(mem_cnt), 129'(c0 + 5));
    mem_return(26'h102, 8'h02);
    mem_return(26'h103, 8'h41);
    mem_return(26'h104, 8'h81);
    mem_return(26'h105, 8'h0C);
    drain("R4 full-table responses drained");
    throttle = 0;

    // R7: frozen after header
    c0 = mem_cnt;
    send_req(26'h2C0, 8'h03);
    repeat (4) @(negedge clk);
    mem_return(26'h2C0, 8'h03);
    drain("R7 first response drained");
    send_req(26'h2C0, 8'h04);
    repeat (4) @(negedge clk);
    check("R7 new read after header", 129'(mem_cnt), 129'(c0 + 2));
    mem_return(26'h2C0, 8'h04);
    drain("R7 second response drained");
    check("R4 no stray reads left", 129'(mq_line.size()), 129'(0));

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule